// File: doc/BRIEF.md
# EDO DRAM Access and Refresh Controller

This block connects a synchronous single-word request stream to an asynchronous 4M x 4-bit extended-data-out DRAM. A requester hands over one access at a time (write flag, 22-bit word address, 4-bit data) on a valid/ready port. The controller splits the address into row and column halves, puts them in turn on a 12-bit multiplexed address bus, and sequences the active-low row strobe, column strobe, write enable and output enable. Every strobe is registered. Every nanosecond timing limit is turned into a clock count by rounding up by the clock-period parameter.

Reads return their nibble on a second valid/ready stream. Back-pressure rules: a request is taken only on a cycle where `req_valid` and `req_ready` are both high. A read response stays valid with fixed data until `rsp_ready` is seen high on a clock edge. While a response is waiting, `req_ready` stays low. A refresh timer asks for a column-before-row refresh cycle at a fixed interval, which by default spreads 2048 refreshes over 32 ms. A pending refresh is served before the next request and never cuts into a row cycle already running.

Top module: `edo_ctrl`

## Requirements
- R1: The row is request address bits [21:11] and the column is bits [10:0]. Each is driven on address pins [10:0], and pin 11 is always 0.
- R2: While reset is held and on the first cycle after it, the row strobe, column strobe, write enable and output enable are high, the data bus is not driven, `rsp_valid` is 0 and `req_ready` is 1.
- R3: In an access, the row address is on the pins when the row strobe falls and stays there for at least 10 ns. The column strobe falls between 14 ns and 45 ns after the row strobe falls.
- R4: The row strobe stays low for at least 60 ns and at most 10,000 ns. In an access, the column strobe is low for at least 10 ns and rises no earlier than 40 ns after the row strobe fell.
- R5: The row strobe stays high for at least 40 ns between low pulses. Its falling edges are at least 104 ns apart. In an access, the column strobe has been high for at least 5 ns when the row strobe falls.
- R6: A write is an early write. When the column strobe falls, write enable is already low and the bus carries the request data. The bus is driven only while the row strobe is low and write enable is low, and it is released when the column strobe rises.
- R7: Output enable is low only while the column strobe is low and write enable is high. Each read produces exactly one response carrying the nibble last written to that address, and writes produce none.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response holds with unchanged data and `req_ready` stays low.
- R9: A refresh drives the column strobe low before the row strobe falls, with write enable high. Refreshes come at least once every refresh interval (1562 clock cycles at the defaults), even under continuous request traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Drive enable for the data bus |
| dram_dq_i | input | 4 | Data read from the memory |

## Verification
The bench uses all-zero, all-one, row-only and column-only addresses. These expose a swapped or shifted row/column split, which would read back the wrong nibble or present the wrong row. A timing model measures every strobe edge in nanoseconds. It catches a row strobe released early, a column strobe dropped before the row address has been held, and a precharge cut short. A design that dropped the held response or took a new request during back-pressure would lose or reorder read data. Long idle stretches and dense traffic both check the refresh spacing, so a refresh that is starved, skipped or issued as a plain row cycle shows up as a gap or a wrong strobe order.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ROW,
    S_RAH,
    S_COL,
    S_CASLO,
    S_CASHI,
    S_PRE,
    S_REFC,
    S_REFR,
    S_PREF
  } seq_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  function automatic int ns2cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL_CYC + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  // R9: a raised refresh request is held until the sequencer takes it
  p_pending_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);

endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int PIN_W = 12
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   sel_col,
  output logic [PIN_W-1:0]       pins
);
  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int FIELD_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [FIELD_W-1:0] row_f, col_f, pick;

  assign row_f = FIELD_W'(addr[ADDR_W-1 -: ROW_W]);
  assign col_f = FIELD_W'(addr[COL_W-1:0]);
  assign pick  = sel_col ? col_f : row_f;

  generate
    if (PIN_W > FIELD_W) begin : g_pad
      assign pins = {{(PIN_W-FIELD_W){1'b0}}, pick};
    end else begin : g_fit
      assign pins = PIN_W'(pick);
    end
  endgenerate

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int CLK_NS    = 10,
  parameter int T_RCD_NS  = 20,
  parameter int T_RAH_NS  = 10,
  parameter int T_CAC_NS  = 15,
  parameter int T_CAS_NS  = 10,
  parameter int T_CAH_NS  = 10,
  parameter int T_CSH_NS  = 40,
  parameter int T_RAS_NS  = 60,
  parameter int T_RP_NS   = 40,
  parameter int T_RC_NS   = 104,
  parameter int T_CSR_NS  = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    rsp_busy,
  input  logic    wr,
  input  logic    ref_pending,
  output logic    req_ready,
  output logic    accept,
  output logic    ref_ack,
  output logic    capture,
  output logic    sel_col_d,
  output strobe_t strobe_q
);
  // clock counts, rounded up
  localparam int C_RCD  = ns2cyc(T_RCD_NS, CLK_NS);
  localparam int C_RAH  = ns2cyc(T_RAH_NS, CLK_NS);
  localparam int C_CASW = imax(imax(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_CAS_NS, CLK_NS)),
                               ns2cyc(T_CAH_NS, CLK_NS));
  localparam int C_CSH  = ns2cyc(T_CSH_NS, CLK_NS);
  localparam int C_RAS  = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int C_RP   = ns2cyc(T_RP_NS, CLK_NS);
  localparam int C_RC   = ns2cyc(T_RC_NS, CLK_NS);
  // per-state durations
  localparam int D_RAH   = C_RAH;
  localparam int D_COL   = imax(C_RCD - C_RAH, 1);
  localparam int D_CASLO = imax(C_CASW, C_CSH - D_RAH - D_COL);
  localparam int D_CASHI = imax(1, C_RAS - (D_RAH + D_COL + D_CASLO));
  localparam int L_ACC   = D_RAH + D_COL + D_CASLO + D_CASHI;
  localparam int D_PRE   = imax(C_RP, C_RC - L_ACC);
  localparam int D_REFC  = ns2cyc(T_CSR_NS, CLK_NS);
  localparam int D_REFR  = C_RAS;
  localparam int D_PREF  = imax(C_RP, C_RC - D_REFR);
  localparam int CNT_W   = 16;

  seq_state_e       state, state_d;
  logic [CNT_W-1:0] cnt;
  logic             last;

  function automatic int dur_of(seq_state_e s);
    case (s)
      S_RAH:   return D_RAH;
      S_COL:   return D_COL;
      S_CASLO: return D_CASLO;
      S_CASHI: return D_CASHI;
      S_PRE:   return D_PRE;
      S_REFC:  return D_REFC;
      S_REFR:  return D_REFR;
      S_PREF:  return D_PREF;
      default: return 1;
    endcase
  endfunction

  function automatic strobe_t decode(seq_state_e s, logic w);
    strobe_t o;
    o.ras_n = 1'b1;
    o.cas_n = 1'b1;
    o.we_n  = 1'b1;
    o.oe_n  = 1'b1;
    o.dq_oe = 1'b0;
    case (s)
      S_RAH, S_COL: begin
        o.ras_n = 1'b0;
        if (w) begin
          o.we_n  = 1'b0;
          o.dq_oe = 1'b1;
        end
      end
      S_CASLO: begin
        o.ras_n = 1'b0;
        o.cas_n = 1'b0;
        if (w) begin
          o.we_n  = 1'b0;
          o.dq_oe = 1'b1;
        end else begin
          o.oe_n = 1'b0;
        end
      end
      S_CASHI: o.ras_n = 1'b0;
      S_REFC:  o.cas_n = 1'b0;
      S_REFR: begin
        o.ras_n = 1'b0;
        o.cas_n = 1'b0;
      end
      default: ;
    endcase
    return o;
  endfunction

  assign last      = (cnt == CNT_W'(dur_of(state) - 1));
  assign req_ready = (state == S_IDLE) && !ref_pending && !rsp_busy;

  always_comb begin
    state_d = state;
    accept  = 1'b0;
    ref_ack = 1'b0;
    capture = 1'b0;
    case (state)
      S_IDLE: begin
        if (ref_pending) begin
          state_d = S_REFC;
          ref_ack = 1'b1;
        end else if (req_valid && !rsp_busy) begin
          state_d = S_ROW;
          accept  = 1'b1;
        end
      end
      S_ROW:   if (last) state_d = S_RAH;
      S_RAH:   if (last) state_d = S_COL;
      S_COL:   if (last) state_d = S_CASLO;
      S_CASLO: begin
        if (last) begin
          state_d = S_CASHI;
          capture = !wr;
        end
      end
      S_CASHI: if (last) state_d = S_PRE;
      S_PRE:   if (last) state_d = S_IDLE;
      S_REFC:  if (last) state_d = S_REFR;
      S_REFR:  if (last) state_d = S_PREF;
      S_PREF:  if (last) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign sel_col_d = (state_d == S_COL) || (state_d == S_CASLO) || (state_d == S_CASHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      cnt            <= '0;
      strobe_q.ras_n <= 1'b1;
      strobe_q.cas_n <= 1'b1;
      strobe_q.we_n  <= 1'b1;
      strobe_q.oe_n  <= 1'b1;
      strobe_q.dq_oe <= 1'b0;
    end else begin
      state    <= state_d;
      cnt      <= (state_d != state || state_d == S_IDLE) ? '0 : cnt + 1'b1;
      strobe_q <= decode(state_d, wr);
    end
  end

  // ---- checks next to the sequencer ----
  logic [CNT_W-1:0] ras_lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n)              ras_lo_run <= '0;
    else if (!strobe_q.ras_n) ras_lo_run <= ras_lo_run + 1'b1;
    else                     ras_lo_run <= '0;
  end

  // R4: row strobe low for the full minimum width
  p_ras_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_q.ras_n) |-> (ras_lo_run >= CNT_W'(C_RAS)));

  // R9: a row-strobe fall with column strobe low must have column strobe low beforehand
  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strobe_q.ras_n) && !strobe_q.cas_n) |-> ($past(strobe_q.cas_n) == 1'b0));

  // R7: output enable only during a read column phase
  p_oe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q.oe_n |-> (!strobe_q.cas_n && strobe_q.we_n));

  // R6: data bus driven only inside a write row cycle
  p_bus_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q.dq_oe |-> (!strobe_q.ras_n && !strobe_q.we_n));

endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ROW_BITS      = 11,
  parameter int COL_BITS      = 11,
  parameter int APIN_BITS     = 12,
  parameter int DQ_BITS       = 4,
  parameter int T_RCD_NS      = 20,
  parameter int T_RAH_NS      = 10,
  parameter int T_CAC_NS      = 15,
  parameter int T_CAS_NS      = 10,
  parameter int T_CAH_NS      = 10,
  parameter int T_CSH_NS      = 40,
  parameter int T_RAS_NS      = 60,
  parameter int T_RP_NS       = 40,
  parameter int T_RC_NS       = 104,
  parameter int T_CSR_NS      = 5,
  parameter int REF_WINDOW_NS = 32000000,
  parameter int REF_ROWS      = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
  input  logic [DQ_BITS-1:0]           req_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [DQ_BITS-1:0]           rsp_rdata,
  output logic                         dram_ras_n,
  output logic                         dram_cas_n,
  output logic                         dram_we_n,
  output logic                         dram_oe_n,
  output logic [APIN_BITS-1:0]         dram_a,
  output logic [DQ_BITS-1:0]           dram_dq_o,
  output logic                         dram_dq_oe,
  input  logic [DQ_BITS-1:0]           dram_dq_i
);
  localparam int ADDR_W   = ROW_BITS + COL_BITS;
  localparam int ROW_NS   = REF_WINDOW_NS / REF_ROWS;
  localparam int REF_CYC  = (ROW_NS / CLK_PERIOD_NS < 2) ? 2 : ROW_NS / CLK_PERIOD_NS;

  logic                 accept, ref_ack, capture, sel_col_d, ref_pending;
  strobe_t              strobe_q;
  logic [ADDR_W-1:0]    addr_q, addr_src;
  logic [DQ_BITS-1:0]   wdata_q;
  logic                 we_q;
  logic [APIN_BITS-1:0] pins_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_write;
    end
  end

  assign addr_src = accept ? req_addr : addr_q;

  edo_refresh_timer #(.INTERVAL_CYC(REF_CYC)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ref_ack),
    .pending (ref_pending)
  );

  edo_addr_mux #(.ROW_W(ROW_BITS), .COL_W(COL_BITS), .PIN_W(APIN_BITS)) u_mux (
    .addr    (addr_src),
    .sel_col (sel_col_d),
    .pins    (pins_d)
  );

  edo_seq #(
    .CLK_NS(CLK_PERIOD_NS), .T_RCD_NS(T_RCD_NS), .T_RAH_NS(T_RAH_NS),
    .T_CAC_NS(T_CAC_NS), .T_CAS_NS(T_CAS_NS), .T_CAH_NS(T_CAH_NS),
    .T_CSH_NS(T_CSH_NS), .T_RAS_NS(T_RAS_NS), .T_RP_NS(T_RP_NS),
    .T_RC_NS(T_RC_NS), .T_CSR_NS(T_CSR_NS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rsp_busy    (rsp_valid),
    .wr          (we_q),
    .ref_pending (ref_pending),
    .req_ready   (req_ready),
    .accept      (accept),
    .ref_ack     (ref_ack),
    .capture     (capture),
    .sel_col_d   (sel_col_d),
    .strobe_q    (strobe_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dram_a <= '0;
    else        dram_a <= pins_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= dram_dq_i;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign dram_ras_n = strobe_q.ras_n;
  assign dram_cas_n = strobe_q.cas_n;
  assign dram_we_n  = strobe_q.we_n;
  assign dram_oe_n  = strobe_q.oe_n;
  assign dram_dq_oe = strobe_q.dq_oe;
  assign dram_dq_o  = wdata_q;

  // R8: a stalled response keeps its data
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R8: no new request while a response waits
  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !accept);

endmodule

// File: tb/tb_edo_ctrl.sv
module tb_edo_ctrl;
  localparam int CLK_NS  = 10;
  localparam int REF_CYC = 1562;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [3:0]  rsp_rdata;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [11:0] dram_a;
  logic [3:0]  dram_dq_o, dram_dq_i, mem_val = '0;

  edo_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_a(dram_a), .dram_dq_o(dram_dq_o),
    .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
  );

  always #5 clk = ~clk;

  assign dram_dq_i = (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) ? mem_val : 4'h0;

  int n_chk = 0, n_fail = 0;
  bit bp_mode = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural memory and bookkeeping
  logic [3:0] mem [int];
  logic [21:0] q_addr[$];
  bit          q_we[$];
  logic [3:0]  q_data[$];
  logic [3:0]  rd_exp[$];
  int cyc = 0, ras_fall = -1000, ras_rise = -1000, cas_fall = -1000, cas_rise = -1000;
  int last_ref = 0, n_ref = 0, n_reads = 0, n_rsp = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, in_acc = 1'b0, row_watch = 1'b0;
  bit prev_bp = 1'b0;
  logic [3:0] prev_rdata = '0;
  logic [10:0] row_lat = '0, col_lat = '0;
  logic [11:0] row_pins = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      // row strobe falls
      if (prev_ras && !dram_ras_n) begin
        chk((cyc - ras_rise) * CLK_NS >= 40, "R5", "precharge ns", (cyc - ras_rise) * CLK_NS, 40);
        chk((cyc - ras_fall) * CLK_NS >= 104, "R5", "cycle ns", (cyc - ras_fall) * CLK_NS, 104);
        if (!dram_cas_n) begin
          chk(dram_we_n && !prev_cas, "R9", "refresh order", int'(dram_we_n), 1);
          chk(cyc - last_ref <= REF_CYC + 30, "R9", "refresh gap", cyc - last_ref, REF_CYC);
          last_ref = cyc;
          n_ref++;
          in_acc = 1'b0;
        end else begin
          in_acc = 1'b1;
          chk((cyc - cas_rise) * CLK_NS >= 5, "R5", "cas high before ras ns", (cyc - cas_rise) * CLK_NS, 5);
          if (q_addr.size() > 0) begin
            chk(dram_a == {1'b0, q_addr[0][21:11]}, "R1", "row pins",
                int'(dram_a), int'({1'b0, q_addr[0][21:11]}));
          end else begin
            chk(1'b0, "R1", "access without request", 0, 1);
          end
          row_pins = dram_a;
          row_lat = dram_a[10:0];
          row_watch = 1'b1;
        end
        ras_fall = cyc;
      end
      // row address hold
      if (row_watch && !dram_ras_n && dram_a != row_pins) begin
        chk((cyc - ras_fall) * CLK_NS >= 10, "R3", "row hold ns", (cyc - ras_fall) * CLK_NS, 10);
        row_watch = 1'b0;
      end
      // column strobe falls inside an access
      if (prev_cas && !dram_cas_n && !dram_ras_n && in_acc) begin
        cas_fall = cyc;
        chk((cyc - ras_fall) * CLK_NS >= 14 && (cyc - ras_fall) * CLK_NS <= 45, "R3", "rcd ns",
            (cyc - ras_fall) * CLK_NS, 14);
        col_lat = dram_a[10:0];
        if (q_addr.size() > 0) begin
          chk(dram_a == {1'b0, q_addr[0][10:0]}, "R1", "column pins",
              int'(dram_a), int'({1'b0, q_addr[0][10:0]}));
          if (q_we[0]) begin
            chk(!dram_we_n && dram_dq_oe && dram_dq_o == q_data[0], "R6", "early write data",
                int'(dram_dq_o), int'(q_data[0]));
            mem[int'({row_lat, col_lat})] = dram_dq_o;
          end else begin
            chk(dram_we_n && !dram_dq_oe, "R7", "read strobes", int'(dram_we_n), 1);
            mem_val = mem.exists(int'({row_lat, col_lat})) ? mem[int'({row_lat, col_lat})] : 4'h0;
            rd_exp.push_back(mem_val);
          end
          void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_data.pop_front());
        end
      end else if (prev_cas && !dram_cas_n) begin
        cas_fall = cyc;
      end
      // column strobe rises inside an access
      if (!prev_cas && dram_cas_n) begin
        if (in_acc) begin
          chk((cyc - cas_fall) * CLK_NS >= 10, "R4", "cas low ns", (cyc - cas_fall) * CLK_NS, 10);
          chk((cyc - ras_fall) * CLK_NS >= 40, "R4", "cas hold after ras ns", (cyc - ras_fall) * CLK_NS, 40);
          chk(!dram_dq_oe, "R6", "bus released", int'(dram_dq_oe), 0);
        end
        cas_rise = cyc;
      end
      // row strobe rises
      if (!prev_ras && dram_ras_n) begin
        chk((cyc - ras_fall) * CLK_NS >= 60 && (cyc - ras_fall) * CLK_NS <= 10000, "R4", "ras low ns",
            (cyc - ras_fall) * CLK_NS, 60);
        ras_rise = cyc;
        in_acc = 1'b0;
        row_watch = 1'b0;
      end
      if (!dram_oe_n)
        chk(!dram_cas_n && dram_we_n, "R7", "oe qualification", int'(dram_cas_n), 0);
      if (dram_dq_oe && dram_ras_n)
        chk(1'b0, "R6", "bus driven outside row cycle", 1, 0);
      // response stream
      if (prev_bp) begin
        chk(rsp_valid && rsp_rdata == prev_rdata, "R8", "held response", int'(rsp_rdata), int'(prev_rdata));
        chk(!req_ready, "R8", "ready low while held", int'(req_ready), 0);
      end
      if (rsp_valid && rsp_ready) begin
        n_rsp++;
        if (rd_exp.size() > 0) begin
          chk(rsp_rdata == rd_exp[0], "R7", "read data", int'(rsp_rdata), int'(rd_exp[0]));
          void'(rd_exp.pop_front());
        end else begin
          chk(1'b0, "R7", "unexpected response", 1, 0);
        end
      end
      prev_bp = rsp_valid && !rsp_ready;
      prev_rdata = rsp_rdata;
      // request accepted at the coming edge
      if (req_valid && req_ready) begin
        q_addr.push_back(req_addr);
        q_we.push_back(req_write);
        q_data.push_back(req_wdata);
        if (!req_write) n_reads++;
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
  end

  always @(posedge clk) begin
    #2;
    rsp_ready = bp_mode ? (($urandom % 4) == 0) : 1'b1;
  end

  task automatic do_req(bit w, logic [21:0] a, logic [3:0] d);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  logic [21:0] pool [12];

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n && !dram_dq_oe && !rsp_valid,
        "R2", "reset strobes", int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && dram_ras_n && dram_cas_n && !rsp_valid, "R2", "ready after reset", int'(req_ready), 1);

    // directed corner addresses
    do_req(1'b1, 22'h000000, 4'h5);
    do_req(1'b1, 22'h3FFFFF, 4'hA);
    do_req(1'b1, 22'h3FF800, 4'h3);
    do_req(1'b1, 22'h0007FF, 4'hC);
    do_req(1'b0, 22'h3FFFFF, 4'h0);
    do_req(1'b0, 22'h000000, 4'h0);
    do_req(1'b0, 22'h0007FF, 4'h0);
    do_req(1'b0, 22'h3FF800, 4'h0);

    for (int i = 0; i < 12; i++) pool[i] = 22'($urandom);
    for (int ph = 0; ph < 2; ph++) begin
      bp_mode = (ph == 1);
      for (int k = 0; k < 250; k++) begin
        do_req(($urandom % 2) == 0, pool[$urandom % 12], 4'($urandom));
      end
    end
    bp_mode = 1'b0;
    repeat (5000) @(posedge clk);
    @(negedge clk);
    chk(n_ref >= (cyc - 40) / REF_CYC, "R9", "refresh count", n_ref, (cyc - 40) / REF_CYC);
    chk(cyc - last_ref <= REF_CYC + 30, "R9", "final refresh gap", cyc - last_ref, REF_CYC);
    chk(n_rsp == n_reads && rd_exp.size() == 0, "R7", "responses per read", n_rsp, n_reads);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

endmodule